// File: doc/BRIEF.md
# Post-Mortem Event Trigger Controller

This block sits beside a timing event generator. It watches one beam-permit flag per ring and decides when the generator should emit a post-mortem event and a per-ring beam-dumped event. Each flag is asynchronous. It passes through a synchronizer, and only a high-to-low transition counts as a dump. Every dump produces a one-cycle `dump_pulse` for that ring, whatever the arming state or the machine mode.

Each ring has its own arming state, which is controlled by decoded arm and disarm command pulses. When a ring is armed, a dump schedules a post-mortem trigger. The trigger fires on the following millisecond tick, and firing consumes the arming. A disarm command starts a timer that re-arms the ring automatically after a fixed number of ticks. While `inject_dump_mode` is high, dumps do not start triggers and do not consume arming.

All rings feed one post-mortem event type. Triggers wait in a pending set and are presented one at a time on a `pm_req`/`pm_ack` handshake, with the lowest ring index served first. A double dump on two armed rings therefore yields two requests inside one millisecond.

Top module: `pm_trigger_ctrl`

## Requirements
- R1: After reset, `pm_req` and `dump_pulse` are low and every ring is armed.
- R2: Each high-to-low transition of `beam_permit[r]` produces exactly one `dump_pulse[r]` that lasts one cycle. This happens regardless of arming and `inject_dump_mode`. A low-to-high transition produces no pulse.
- R3: A falling flag on an armed ring, with `inject_dump_mode` low, raises `pm_req` no later than `TRIG_DELAY_TICKS` ticks plus a few cycles afterwards. When it is presented, `pm_ring` equals the ring index (0 = first ring, 1 = second ring).
- R4: A ring that has fired is disarmed. A later fall on that ring raises no request until the ring is re-armed.
- R5: After `disarm_cmd[r]`, a fall on ring r raises no request. If disarm and arm arrive in the same cycle, disarm wins.
- R6: A disarm re-arms its ring automatically once `REARM_TICKS` ticks have passed.
- R7: `arm_cmd[r]` re-arms ring r and cancels a pending automatic re-arm.
- R8: A fall while `inject_dump_mode` is high raises no request and leaves the ring armed.
- R9: `pm_req` stays high with `pm_ring` stable until `pm_ack` is seen. It is low in the cycle after the acknowledge. `pm_ack` while `pm_req` is low has no effect.
- R10: Triggers from several rings are served one after another, lowest index first. The next request is raised in the second cycle after the previous acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beam_permit | input | NUM_RINGS | Asynchronous beam-permit flag per ring, high = permit present |
| arm_cmd | input | NUM_RINGS | One-cycle decoded arm command per ring |
| disarm_cmd | input | NUM_RINGS | One-cycle decoded disarm command per ring |
| inject_dump_mode | input | 1 | High = inhibit post-mortem triggers |
| pm_ack | input | 1 | Acknowledge from the event generator |
| pm_req | output | 1 | Post-mortem request, held until acknowledged |
| pm_ring | output | RING_W | Ring that caused the presented request |
| dump_pulse | output | NUM_RINGS | One-cycle beam-dumped request per ring |

## Verification
The bench sweeps every combination of ring, mode and arming state. In each case it checks that the dump pulse always appears exactly once, and that a request appears only for an armed ring outside inject-and-dump mode. A design that gated the dump pulse with the inhibit, or that fired on rising flags, would show a wrong pulse count. A design that did not consume arming, or that let the inhibit consume it, fails the refire checks. A design whose re-arm timer never expires fails the auto-rearm check. With both rings dumping together, the bench withholds the acknowledge to show that the first request is held. It then checks that the second request follows promptly. This catches an arbiter that drops, merges or reorders the two triggers.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  // Counter width able to hold values 0..n, never below one bit.
  function automatic int cnt_w(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pmt_sync_fall.sv
module pmt_sync_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic fall
);
  logic [STAGES-1:0] shreg;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '1;
      last  <= 1'b1;
      fall  <= 1'b0;
    end else begin
      shreg <= {shreg[STAGES-2:0], async_in};
      last  <= shreg[STAGES-1];
      fall  <= last & ~shreg[STAGES-1];
    end
  end
endmodule

// File: rtl/pmt_tick.sv
module pmt_tick #(
  parameter int DIV = 40000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/pmt_ring_arm.sv
module pmt_ring_arm
  import pmt_pkg::*;
#(
  parameter int DLY_TICKS  = 1,
  parameter int REARM_TICKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic fall,
  input  logic arm,
  input  logic disarm,
  input  logic inhibit,
  output logic armed,
  output logic fire
);
  localparam int DW = cnt_w(DLY_TICKS);
  localparam int RW = cnt_w(REARM_TICKS);

  logic [DW-1:0] dly_cnt;
  logic          dly_act;
  logic [RW-1:0] rearm_cnt;
  logic          rearm_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b1;
      fire      <= 1'b0;
      dly_cnt   <= '0;
      dly_act   <= 1'b0;
      rearm_cnt <= '0;
      rearm_act <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (dly_act && tick) begin
        if (dly_cnt == DW'(1)) begin
          fire    <= 1'b1;
          dly_act <= 1'b0;
        end else begin
          dly_cnt <= dly_cnt - 1'b1;
        end
      end
      if (disarm) begin
        armed     <= 1'b0;
        dly_act   <= 1'b0;
        fire      <= 1'b0;
        rearm_act <= 1'b1;
        rearm_cnt <= RW'(REARM_TICKS);
      end else begin
        if (arm) begin
          armed     <= 1'b1;
          rearm_act <= 1'b0;
        end else if (rearm_act && tick) begin
          if (rearm_cnt == RW'(1)) begin
            armed     <= 1'b1;
            rearm_act <= 1'b0;
          end else begin
            rearm_cnt <= rearm_cnt - 1'b1;
          end
        end
        if (fall && armed && !inhibit) begin
          armed   <= 1'b0;
          dly_act <= 1'b1;
          dly_cnt <= DW'(DLY_TICKS);
        end
      end
    end
  end
endmodule

// File: rtl/pmt_pm_arb.sv
module pmt_pm_arb #(
  parameter int N  = 2,
  parameter int RW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  fire,
  input  logic          ack,
  output logic          req,
  output logic [RW-1:0] ring
);
  logic [N-1:0]  pend;
  logic [N-1:0]  pend_nx;
  logic [RW-1:0] pick;

  always_comb begin
    pend_nx = pend | fire;
    pick    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_nx[i]) pick = RW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      req  <= 1'b0;
      ring <= '0;
    end else begin
      pend <= pend_nx;
      if (req) begin
        if (ack) req <= 1'b0;
      end else if (|pend_nx) begin
        req  <= 1'b1;
        ring <= pick;
        pend <= pend_nx & ~(N'(1) << pick);
      end
    end
  end
endmodule

// File: rtl/pm_trigger_ctrl.sv
module pm_trigger_ctrl #(
  parameter int NUM_RINGS        = 2,
  parameter int SYNC_STAGES      = 2,
  parameter int TICK_DIV         = 40000,
  parameter int TRIG_DELAY_TICKS = 1,
  parameter int REARM_TICKS      = 2,
  parameter int RING_W           = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_RINGS-1:0] beam_permit,
  input  logic [NUM_RINGS-1:0] arm_cmd,
  input  logic [NUM_RINGS-1:0] disarm_cmd,
  input  logic                 inject_dump_mode,
  input  logic                 pm_ack,
  output logic                 pm_req,
  output logic [RING_W-1:0]    pm_ring,
  output logic [NUM_RINGS-1:0] dump_pulse
);
  logic                 tick;
  logic [NUM_RINGS-1:0] ring_fall;
  logic [NUM_RINGS-1:0] ring_armed;
  logic [NUM_RINGS-1:0] ring_fire;

  pmt_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    pmt_sync_fall #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_in(beam_permit[g]), .fall(ring_fall[g])
    );
    pmt_ring_arm #(.DLY_TICKS(TRIG_DELAY_TICKS), .REARM_TICKS(REARM_TICKS)) u_arm (
      .clk(clk), .rst(rst), .tick(tick), .fall(ring_fall[g]),
      .arm(arm_cmd[g]), .disarm(disarm_cmd[g]), .inhibit(inject_dump_mode),
      .armed(ring_armed[g]), .fire(ring_fire[g])
    );
  end

  assign dump_pulse = ring_fall;

  pmt_pm_arb #(.N(NUM_RINGS), .RW(RING_W)) u_arb (
    .clk(clk), .rst(rst), .fire(ring_fire), .ack(pm_ack),
    .req(pm_req), .ring(pm_ring)
  );
endmodule

// File: rtl/pm_trigger_ctrl_chk.sv
module pm_trigger_ctrl_chk #(
  parameter int NUM_RINGS = 2,
  parameter int RING_W    = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_RINGS-1:0] dump_pulse,
  input logic [NUM_RINGS-1:0] disarm_cmd,
  input logic [NUM_RINGS-1:0] ring_armed,
  input logic                 pm_req,
  input logic                 pm_ack,
  input logic [RING_W-1:0]    pm_ring
);
  // R2
  dump_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (|dump_pulse) |=> ((dump_pulse & $past(dump_pulse)) == '0));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_req && !pm_ack) |=> (pm_req && $stable(pm_ring)));

  // R9
  req_release_chk: assert property (@(posedge clk) disable iff (rst)
    (pm_req && pm_ack) |=> !pm_req);

  // R5
  disarm_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (|disarm_cmd) |=> ((ring_armed & $past(disarm_cmd)) == '0));
endmodule

bind pm_trigger_ctrl pm_trigger_ctrl_chk #(.NUM_RINGS(NUM_RINGS), .RING_W(RING_W)) u_chk (
  .clk(clk), .rst(rst), .dump_pulse(dump_pulse), .disarm_cmd(disarm_cmd),
  .ring_armed(ring_armed), .pm_req(pm_req), .pm_ack(pm_ack), .pm_ring(pm_ring)
);

// File: tb/pm_trigger_ctrl_tb.sv
`timescale 1ns/1ps
module pm_trigger_ctrl_tb;
  localparam int TD = 8;
  localparam int DL = 1;
  localparam int RE = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] beam_permit = 2'b11;
  logic [1:0] arm_cmd = '0;
  logic [1:0] disarm_cmd = '0;
  logic       inject_dump_mode = 1'b0;
  logic       pm_ack = 1'b0;
  logic       pm_req;
  logic [0:0] pm_ring;
  logic [1:0] dump_pulse;

  always #2 clk = ~clk;

  pm_trigger_ctrl #(.NUM_RINGS(2), .TICK_DIV(TD), .TRIG_DELAY_TICKS(DL),
                    .REARM_TICKS(RE)) u_dut (
    .clk(clk), .rst(rst), .beam_permit(beam_permit), .arm_cmd(arm_cmd),
    .disarm_cmd(disarm_cmd), .inject_dump_mode(inject_dump_mode),
    .pm_ack(pm_ack), .pm_req(pm_req), .pm_ring(pm_ring), .dump_pulse(dump_pulse)
  );

  int checks = 0;
  int fails  = 0;
  int dc[2]  = '{0, 0};

  always @(posedge clk) begin
    if (!rst) begin
      if (dump_pulse[0]) dc[0] <= dc[0] + 1;
      if (dump_pulse[1]) dc[1] <= dc[1] + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_req(input int win, output bit got, output int ring);
    got = 1'b0;
    ring = -1;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (pm_req) begin
        got = 1'b1;
        ring = int'(pm_ring);
        break;
      end
    end
  endtask

  task automatic do_ack(input string req);
    pm_ack = 1'b1;
    @(negedge clk);
    pm_ack = 1'b0;
    chk(!pm_req, req, int'(pm_req), 0);
  endtask

  task automatic pulse_cmd(input bit is_arm, input int r);
    if (is_arm) arm_cmd[r] = 1'b1; else disarm_cmd[r] = 1'b1;
    @(negedge clk);
    arm_cmd = '0;
    disarm_cmd = '0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit got;
    int ring;
    int d0;
    cyc(3);
    rst = 1'b0;
    cyc(2);
    // R1 reset state
    chk(!pm_req, "R1 pm_req", int'(pm_req), 0);
    chk(dump_pulse == 2'b00, "R1 dump_pulse", int'(dump_pulse), 0);

    // Sweep: ring x mode x arming
    for (int r = 0; r < 2; r++) begin
      for (int m = 0; m < 2; m++) begin
        for (int a = 0; a < 2; a++) begin
          inject_dump_mode = m[0];
          pulse_cmd(a[0], r);
          d0 = dc[r];
          beam_permit[r] = 1'b0;
          wait_req(2 * TD + 10, got, ring);
          // R3 R5 R8: request only when armed and not inhibited
          chk(got == (a[0] && !m[0]), "R3 sweep request", int'(got), int'(a[0] && !m[0]));
          if (got) begin
            chk(ring == r, "R3 pm_ring", ring, r);
            do_ack("R9 release");
          end
          // R2 one dump pulse regardless of arming/mode
          chk(dc[r] - d0 == 1, "R2 dump count", dc[r] - d0, 1);
          beam_permit[r] = 1'b1;
          cyc(6);
          chk(dc[r] - d0 == 1, "R2 rising no pulse", dc[r] - d0, 1);
          inject_dump_mode = 1'b0;
          cyc(RE * TD + 4);
          pulse_cmd(1'b1, r);
          cyc(2);
        end
      end
    end

    // R4 consume on fire
    beam_permit[0] = 1'b0;
    wait_req(2 * TD + 10, got, ring);
    chk(got, "R3 armed fire", int'(got), 1);
    if (got) do_ack("R9 release");
    beam_permit[0] = 1'b1;
    cyc(6);
    beam_permit[0] = 1'b0;
    wait_req(3 * TD, got, ring);
    chk(!got, "R4 consumed", int'(got), 0);
    beam_permit[0] = 1'b1;
    cyc(6);
    // R7 arm re-arms
    pulse_cmd(1'b1, 0);
    beam_permit[0] = 1'b0;
    wait_req(2 * TD + 10, got, ring);
    chk(got, "R7 rearm by command", int'(got), 1);
    if (got) do_ack("R9 release");
    beam_permit[0] = 1'b1;
    cyc(6);

    // R5 disarm then R6 automatic re-arm
    pulse_cmd(1'b0, 1);
    beam_permit[1] = 1'b0;
    wait_req(3 * TD, got, ring);
    chk(!got, "R5 disarmed", int'(got), 0);
    beam_permit[1] = 1'b1;
    cyc(RE * TD + 4);
    beam_permit[1] = 1'b0;
    wait_req(2 * TD + 10, got, ring);
    chk(got && ring == 1, "R6 auto rearm", int'(got), 1);
    if (got) do_ack("R9 release");
    beam_permit[1] = 1'b1;
    cyc(6);
    pulse_cmd(1'b1, 0);
    pulse_cmd(1'b1, 1);

    // R5 disarm beats arm in same cycle
    arm_cmd[0] = 1'b1;
    disarm_cmd[0] = 1'b1;
    @(negedge clk);
    arm_cmd = '0;
    disarm_cmd = '0;
    beam_permit[0] = 1'b0;
    wait_req(3 * TD, got, ring);
    chk(!got, "R5 disarm priority", int'(got), 0);
    beam_permit[0] = 1'b1;
    cyc(RE * TD + 4);
    pulse_cmd(1'b1, 0);

    // R8 inhibit keeps arming
    inject_dump_mode = 1'b1;
    beam_permit[0] = 1'b0;
    wait_req(3 * TD, got, ring);
    chk(!got, "R8 inhibited", int'(got), 0);
    beam_permit[0] = 1'b1;
    inject_dump_mode = 1'b0;
    cyc(6);
    beam_permit[0] = 1'b0;
    wait_req(2 * TD + 10, got, ring);
    chk(got, "R8 arming kept", int'(got), 1);
    if (got) do_ack("R9 release");
    beam_permit[0] = 1'b1;
    cyc(6);
    pulse_cmd(1'b1, 0);

    // R9 idle ack ignored, R10 double dump serialized
    pm_ack = 1'b1;
    cyc(2);
    pm_ack = 1'b0;
    beam_permit = 2'b00;
    wait_req(2 * TD + 10, got, ring);
    chk(got && ring == 0, "R10 first ring0", ring, 0);
    cyc(20);
    chk(pm_req && pm_ring == 1'b0, "R9 held", int'(pm_req), 1);
    do_ack("R9 release");
    wait_req(4, got, ring);
    chk(got && ring == 1, "R10 second ring1", ring, 1);
    if (got) do_ack("R9 release");
    wait_req(3 * TD, got, ring);
    chk(!got, "R10 no extra", int'(got), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule